// File: doc/BRIEF.md
# Guarded Wide-Instruction Issue and Delayed-Jump Sequencer

This block sits at the front of a statically scheduled wide-instruction core. Each cycle that fetch reports a bundle ready, the block reads the bundle. A bundle holds five fixed-width operation fields and one jump flag. The block also reads the value of the guard register the bundle names. It then raises one issue-valid bit per operation field towards the functional units. A zero guard cancels every field of the bundle at once. A field holding the empty-operation code never issues. The compiler owns all dependency spacing, so the block does no hazard or interlock checking.

The block also drives the fetch address. Jumps are of the jump-if-false form. Only the jump depends on the condition; the other fields of the bundle issue normally. The jump takes effect after a fixed number of delay bundles, three by default, and those bundles always run. A small two-state machine tracks the pending jump. In state ST_LINEAR no jump is pending. Transition T_ARM moves it to ST_SHADOW when a flagged bundle is accepted with a false condition. In ST_SHADOW the target is held and a counter counts accepted delay bundles. Transition T_LAND returns it to ST_LINEAR at the last delay bundle, and the fetch address then loads the target. Stall cycles never change the state, the counter or the target. A jump flag found inside the shadow is reported as an illegal sequence and is otherwise discarded.

Top module: `bundle_issue_seq`

## Requirements
- R1: While reset is asserted and in the cycle after it, fetch_addr equals BOOT_ADDR (0x0100), issue_vld is zero, seq_err is zero and no jump is pending.
- R2: When a bundle is accepted (fetch_rdy high) with a nonzero guard_val, issue_vld bit i in the next cycle is high exactly when field i, bits [i*8+7:i*8] of instr_word, is not the empty-operation code 0x00.
- R3: When a bundle is accepted with guard_val equal to zero, issue_vld is all zeros in the next cycle, whatever the field contents.
- R4: In a cycle with fetch_rdy low, issue_vld is all zeros in the next cycle and fetch_addr keeps its value.
- R5: Each accepted bundle with no pending jump advances fetch_addr by one, wrapping at the address width.
- R6: An accepted bundle with the jump flag (instr_word bit 40) set and jmp_cond equal to 0 captures jmp_tgt in that cycle. The next three accepted fetches use the three following sequential addresses, and the fetch after them uses the captured target. Later changes of jmp_tgt have no effect.
- R7: An accepted bundle with the jump flag set and jmp_cond equal to 1 does not redirect, and fetch_addr advances by one.
- R8: The guard value does not gate the jump. A taken jump in a bundle whose guard is zero still redirects after the delay bundles, and the jump flag does not gate that bundle's issue mask.
- R9: Stall cycles inside the delay window do not consume delay bundles. The redirect happens after three accepted fetches, however many stall cycles come between them.
- R10: An accepted bundle with the jump flag set while a jump is pending raises seq_err for the next cycle. Its condition and target are ignored, and the pending count and target are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_rdy | input | 1 | The bundle at fetch_addr is present this cycle |
| instr_word | input | 41 | Five 8-bit operation fields in bits 39:0, jump flag in bit 40 |
| guard_val | input | 32 | Value of the guard register named by the bundle |
| jmp_cond | input | 1 | Jump condition; the jump is taken when it is 0 |
| jmp_tgt | input | 16 | Jump target bundle address |
| fetch_addr | output | 16 | Address of the bundle to fetch |
| issue_vld | output | 5 | Per-field issue-valid, registered |
| seq_err | output | 1 | Illegal jump inside a delay window, one-cycle pulse |

## Verification
The assertions assume that instr_word, guard_val, jmp_cond and jmp_tgt only matter when fetch_rdy is high. They also assume that reset is held for at least one clock edge before any property is evaluated. They make no assumption about how often jumps occur, so they also cover back-to-back jumps inside a delay window. The stimulus changes inputs only at the falling edge. It draws fetch_rdy, zero guards, empty fields, jump flags and conditions at fixed rates from a seeded generator, so stalls, nested jumps and zero guards all occur inside delay windows. Directed sequences add the guard-zero jump, the stalled window and the ignored nested jump.

// File: rtl/bis_pkg.sv
package bis_pkg;
    typedef enum logic {
        ST_LINEAR = 1'b0,
        ST_SHADOW = 1'b1
    } seq_state_e;
endpackage

// File: rtl/bis_slot_gate.sv
module bis_slot_gate #(
    parameter int NSLOT = 5,
    parameter int OP_W  = 8,
    parameter int GRD_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take,
    input  logic [NSLOT*OP_W-1:0] ops,
    input  logic [GRD_W-1:0]      guard,
    output logic [NSLOT-1:0]      issue_vld
);
    logic [NSLOT-1:0] live;
    logic             guard_on;

    assign guard_on = |guard;

    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            assign live[s] = |ops[s*OP_W +: OP_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)
            issue_vld <= '0;
        else if (take && guard_on)
            issue_vld <= live;
        else
            issue_vld <= '0;
    end
endmodule

// File: rtl/bis_delay_fsm.sv
module bis_delay_fsm
    import bis_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int DELAY = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic            jmp_flag,
    input  logic            jmp_cond,
    input  logic [PC_W-1:0] jmp_tgt,
    output logic            redirect,
    output logic [PC_W-1:0] redir_addr,
    output logic            shadow_act,
    output logic            seq_err
);
    localparam int CNT_W = $clog2(DELAY + 1);

    seq_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             t_arm, t_land;

    assign t_arm  = take && jmp_flag && !jmp_cond;
    assign t_land = take && (cnt == CNT_W'(1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LINEAR: if (t_arm)  state_nx = ST_SHADOW;
            ST_SHADOW: if (t_land) state_nx = ST_LINEAR;
            default:               state_nx = ST_LINEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_LINEAR;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            redir_addr <= '0;
            seq_err    <= 1'b0;
        end else begin
            seq_err <= 1'b0;
            unique case (state)
                ST_LINEAR: begin
                    if (t_arm) begin
                        cnt        <= CNT_W'(DELAY);
                        redir_addr <= jmp_tgt;
                    end
                end
                ST_SHADOW: begin
                    if (take) begin
                        cnt     <= cnt - CNT_W'(1);
                        seq_err <= jmp_flag;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    assign shadow_act = (state == ST_SHADOW);
    assign redirect   = shadow_act && t_land;
endmodule

// File: rtl/bis_pc_unit.sv
module bis_pc_unit #(
    parameter int              PC_W      = 16,
    parameter logic [PC_W-1:0] BOOT_ADDR = 16'h0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic            redirect,
    input  logic [PC_W-1:0] redir_addr,
    output logic [PC_W-1:0] fetch_addr
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            fetch_addr <= BOOT_ADDR;
        else if (redirect)
            fetch_addr <= redir_addr;
        else if (take)
            fetch_addr <= fetch_addr + PC_W'(1);
    end
endmodule

// File: rtl/bundle_issue_seq.sv
module bundle_issue_seq #(
    parameter int              NSLOT     = 5,
    parameter int              OP_W      = 8,
    parameter int              GRD_W     = 32,
    parameter int              PC_W      = 16,
    parameter int              DELAY     = 3,
    parameter logic [PC_W-1:0] BOOT_ADDR = 16'h0100,
    localparam int             IW        = NSLOT * OP_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_rdy,
    input  logic [IW-1:0]    instr_word,
    input  logic [GRD_W-1:0] guard_val,
    input  logic             jmp_cond,
    input  logic [PC_W-1:0]  jmp_tgt,
    output logic [PC_W-1:0]  fetch_addr,
    output logic [NSLOT-1:0] issue_vld,
    output logic             seq_err
);
    logic            jmp_flag;
    logic            redirect;
    logic            shadow_act;
    logic [PC_W-1:0] redir_addr;

    assign jmp_flag = instr_word[IW-1];

    bis_slot_gate #(.NSLOT(NSLOT), .OP_W(OP_W), .GRD_W(GRD_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .take(fetch_rdy),
        .ops(instr_word[IW-2:0]), .guard(guard_val), .issue_vld(issue_vld)
    );

    bis_delay_fsm #(.PC_W(PC_W), .DELAY(DELAY)) u_dly (
        .clk(clk), .rst_n(rst_n), .take(fetch_rdy), .jmp_flag(jmp_flag),
        .jmp_cond(jmp_cond), .jmp_tgt(jmp_tgt), .redirect(redirect),
        .redir_addr(redir_addr), .shadow_act(shadow_act), .seq_err(seq_err)
    );

    bis_pc_unit #(.PC_W(PC_W), .BOOT_ADDR(BOOT_ADDR)) u_pc (
        .clk(clk), .rst_n(rst_n), .take(fetch_rdy), .redirect(redirect),
        .redir_addr(redir_addr), .fetch_addr(fetch_addr)
    );
endmodule

// File: rtl/bis_checks.sv
module bis_checks #(
    parameter int NSLOT = 5,
    parameter int OP_W  = 8,
    parameter int GRD_W = 32,
    parameter int PC_W  = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  fetch_rdy,
    input logic [NSLOT*OP_W:0]   instr_word,
    input logic [GRD_W-1:0]      guard_val,
    input logic [PC_W-1:0]       fetch_addr,
    input logic [NSLOT-1:0]      issue_vld,
    input logic                  seq_err,
    input logic                  shadow_act
);
    p_nop_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rdy && (guard_val != '0) && (instr_word[OP_W-1:0] == '0) |=> !issue_vld[0]);

    p_guard_cancel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rdy && (guard_val == '0) |=> (issue_vld == '0));

    p_stall_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_rdy |=> (issue_vld == '0) && $stable(fetch_addr));

    p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rdy && !shadow_act |=> fetch_addr == $past(fetch_addr) + PC_W'(1));

    p_err_in_shadow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> $past(shadow_act) && $past(fetch_rdy));

    p_no_err_linear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !shadow_act |=> !seq_err);
endmodule

bind bundle_issue_seq bis_checks #(
    .NSLOT(NSLOT), .OP_W(OP_W), .GRD_W(GRD_W), .PC_W(PC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_rdy(fetch_rdy), .instr_word(instr_word),
    .guard_val(guard_val), .fetch_addr(fetch_addr), .issue_vld(issue_vld),
    .seq_err(seq_err), .shadow_act(shadow_act)
);

// File: tb/bundle_issue_seq_bench.sv
module bundle_issue_seq_bench;
    localparam int NSLOT = 5;
    localparam int OP_W  = 8;
    localparam int IW    = NSLOT * OP_W + 1;
    localparam logic [15:0] BOOT = 16'h0100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_rdy = 1'b0;
    logic [IW-1:0] instr_word = '0;
    logic [31:0]   guard_val = '0;
    logic          jmp_cond = 1'b0;
    logic [15:0]   jmp_tgt = '0;
    logic [15:0]   fetch_addr;
    logic [4:0]    issue_vld;
    logic          seq_err;

    always #2.5 clk = ~clk;

    bundle_issue_seq u_bundle_issue_seq (
        .clk(clk), .rst_n(rst_n), .fetch_rdy(fetch_rdy), .instr_word(instr_word),
        .guard_val(guard_val), .jmp_cond(jmp_cond), .jmp_tgt(jmp_tgt),
        .fetch_addr(fetch_addr), .issue_vld(issue_vld), .seq_err(seq_err)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    logic [15:0] m_pc;
    logic [4:0]  m_mask;
    logic        m_err;
    bit          m_pend;
    int          m_cnt;
    logic [15:0] m_tgt;
    bit          m_stalled;
    bit          m_gz;
    string       tag_pc, tag_mask;

    function automatic logic [4:0] exp_mask(logic [IW-1:0] w, logic [31:0] g);
        logic [4:0] r = '0;
        if (g != 0)
            for (int s = 0; s < NSLOT; s++) r[s] = (w[s*OP_W +: OP_W] != 8'h00);
        return r;
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(tag_pc, "fetch_addr", fetch_addr, m_pc);
        chk(tag_mask, "issue_vld", issue_vld, m_mask);
        chk("R10", "seq_err", seq_err, m_err);
    endtask

    task automatic step(input logic rdy, input logic [IW-1:0] w, input logic [31:0] g,
                        input logic c, input logic [15:0] t);
        fetch_rdy = rdy; instr_word = w; guard_val = g; jmp_cond = c; jmp_tgt = t;
        m_err = 1'b0;
        if (!rdy) begin
            m_mask = '0; tag_mask = "R4"; tag_pc = "R4";
            if (m_pend) m_stalled = 1'b1;
        end else begin
            m_mask   = exp_mask(w, g);
            tag_mask = (g == 0) ? "R3" : "R2";
            if (m_pend) begin
                if (w[IW-1]) m_err = 1'b1;
                if (m_cnt == 1) begin
                    m_pc   = m_tgt; m_pend = 1'b0;
                    tag_pc = m_stalled ? "R9" : (m_gz ? "R8" : "R6");
                end else begin
                    m_pc = m_pc + 16'd1; m_cnt--; tag_pc = "R6";
                end
            end else begin
                if (w[IW-1] && !c) begin
                    m_pend = 1'b1; m_cnt = 3; m_tgt = t; m_stalled = 1'b0;
                    m_gz = (g == 0);
                end
                tag_pc = (w[IW-1] && c) ? "R7" : "R5";
                m_pc = m_pc + 16'd1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [IW-1:0] mk_word(bit jb, int zero_pct);
        logic [IW-1:0] w = '0;
        for (int s = 0; s < NSLOT; s++) begin
            logic [7:0] op = 8'($urandom);
            if (($urandom % 100) < zero_pct) op = 8'h00;
            w[s*OP_W +: OP_W] = op;
        end
        w[IW-1] = jb;
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R5 watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_pc = BOOT; m_mask = '0; m_err = 1'b0; m_pend = 1'b0; m_cnt = 0;
        m_tgt = '0; m_stalled = 1'b0; m_gz = 1'b0;
        repeat (3) @(negedge clk);
        tag_pc = "R1"; tag_mask = "R1";
        compare_all();
        fetch_rdy = 1'b1; instr_word = {1'b1, 40'hFF_FF_FF_FF_FF}; guard_val = 32'h1;
        @(negedge clk);
        compare_all();
        rst_n = 1'b1;
        fetch_rdy = 1'b0;
        @(negedge clk);
        compare_all();

        // R2: mixed empty fields, nonzero guard
        step(1'b1, {1'b0, 40'h00_12_00_34_00}, 32'h8000_0000, 1'b0, 16'h0);
        // R3: guard zero cancels full bundle
        step(1'b1, {1'b0, 40'h11_22_33_44_55}, 32'h0, 1'b0, 16'h0);
        // R7: not-taken jump
        step(1'b1, {1'b1, 40'h01_00_00_00_00}, 32'h5, 1'b1, 16'h0777);
        // R8: taken jump with zero guard, then straight delay bundles
        step(1'b1, {1'b1, 40'h01_02_03_04_05}, 32'h0, 1'b0, 16'h0200);
        for (int k = 0; k < 3; k++) step(1'b1, mk_word(1'b0, 30), 32'h3, 1'b0, 16'hBEEF);
        // R9 and R10: stalls and an ignored nested jump inside the window
        step(1'b1, mk_word(1'b1, 0), 32'h1, 1'b0, 16'h0400);
        step(1'b0, mk_word(1'b0, 0), 32'h1, 1'b0, 16'h0);
        step(1'b0, mk_word(1'b0, 0), 32'h1, 1'b0, 16'h0);
        step(1'b1, mk_word(1'b1, 0), 32'h1, 1'b0, 16'h0999);
        step(1'b0, mk_word(1'b0, 0), 32'h1, 1'b0, 16'h0);
        step(1'b1, mk_word(1'b1, 0), 32'h1, 1'b1, 16'h0AAA);
        step(1'b1, mk_word(1'b0, 0), 32'h1, 1'b0, 16'h0BBB);
        chk("R9", "landed at held target", fetch_addr, 16'h0400);
        // R5: wrap at address width
        step(1'b1, {1'b1, 40'h0}, 32'h1, 1'b0, 16'hFFFF);
        for (int k = 0; k < 4; k++) step(1'b1, mk_word(1'b0, 30), 32'h1, 1'b0, 16'h0);
        chk("R5", "wrapped address", fetch_addr, 16'h0000);

        for (int n = 0; n < 4000; n++) begin
            bit          rdy = (($urandom % 100) < 80);
            bit          jb  = (($urandom % 100) < 15);
            logic [31:0] g   = (($urandom % 100) < 25) ? 32'h0 : 32'($urandom);
            step(rdy, mk_word(jb, 30), g, 1'($urandom), 16'($urandom));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule